// File: doc/BRIEF.md
# Integer Issue Queue with Two-Port ALU Steering

This block holds up to sixteen renamed integer instructions while they wait for their source operands. Each instruction carries two physical source tags with ready flags, a destination tag and a two-bit operation class. Every cycle the queue compares the waiting source tags against up to two result-tag broadcasts and marks the matching operands ready. It then picks at most one ready instruction for each of two ALU ports. The choice follows the operation class and, within the class rules, takes the oldest instruction first.

The caller offers up to four instructions per cycle on parallel lanes. They are accepted only while `can_accept` is high. Accepted instructions land in whatever slots are free, with no ordering among slots. A slot is released in the cycle its instruction is sent to an ALU. A divide keeps ALU port B occupied for a fixed number of cycles after it issues. A flush empties the queue in one cycle.

Top module: `int_issue_queue`

## Requirements
- R1: The queue holds DEPTH=16 entries. `can_accept` is high exactly when the number of free entries is at least the number of lanes set in `in_valid`. When `can_accept` is low or `flush` is high, no lane is written.
- R2: An entry becomes free at the clock edge that ends the cycle in which it is presented on an issue port. The free count includes it from the next cycle on.
- R3: The class encoding is 0 general, 1 branch or shift, 2 multiply, 3 divide. Port A (ALU1) issues only classes 0 and 1. Port B (ALU2) issues only classes 0, 2 and 3.
- R4: Each port issues at most one instruction per cycle. The two ports never present the same entry in one cycle.
- R5: An entry is eligible only when both source operands are ready. A broadcast marks a matching operand ready at the next edge. That entry can issue in the cycle after the broadcast, never in the broadcast cycle itself.
- R6: A broadcast on `bc_valid`/`bc_tag` in the same cycle that an instruction is written marks the matching source operand ready.
- R7: Among eligible entries for a port, the oldest issues first. Age is the order of acceptance, and within one cycle a lower lane counts as older.
- R8: Port A takes the oldest ready branch/shift entry if there is one. Only otherwise does it take the oldest ready general entry. Port B takes the oldest remaining eligible entry of class 0, 2 or 3.
- R9: After a divide issues on port B in cycle t, port B issues nothing in cycles t+1 through t+DIV_BUSY (default 6).
- R10: While `flush` is high, nothing issues and nothing is written. At the next edge all entries become invalid, so later broadcasts cannot bring any old entry back.
- R11: After reset the queue is empty, nothing issues and four lanes can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard every queued instruction |
| in_valid | input | LANES | Lane k offers an instruction |
| in_src1 | input | LANES x TAG_W | First source tag per lane |
| in_src1_rdy | input | LANES | First source already ready |
| in_src2 | input | LANES x TAG_W | Second source tag per lane |
| in_src2_rdy | input | LANES | Second source already ready |
| in_dst | input | LANES x TAG_W | Destination tag per lane |
| in_cls | input | LANES x 2 | Operation class per lane |
| can_accept | output | 1 | Enough free entries for the lanes offered |
| bc_valid | input | NBC | Result broadcast valid |
| bc_tag | input | NBC x TAG_W | Broadcast result tags |
| iss_a_valid | output | 1 | Instruction issued to ALU1 |
| iss_a_src1 | output | TAG_W | ALU1 first source tag |
| iss_a_src2 | output | TAG_W | ALU1 second source tag |
| iss_a_dst | output | TAG_W | ALU1 destination tag |
| iss_a_cls | output | 2 | ALU1 operation class |
| iss_b_valid | output | 1 | Instruction issued to ALU2 |
| iss_b_src1 | output | TAG_W | ALU2 first source tag |
| iss_b_src2 | output | TAG_W | ALU2 second source tag |
| iss_b_dst | output | TAG_W | ALU2 destination tag |
| iss_b_cls | output | 2 | ALU2 operation class |

## Verification
Two pairs of functions can fall in the same cycle.

- **Write and broadcast together.** An instruction is written in the same cycle that its source tags are broadcast. Because that operand is marked ready, the instruction must appear on port A in the very next cycle.
- **Both ports in one cycle.** A branch and a general instruction, or two general instructions, are written in one cycle. In the next cycle both ports must issue, each with the destination tag its class and age rule predicts.

The divide hold is checked at every cycle of its window. Over the same cycles, later multiplies queue up and must then leave in age order.

// File: rtl/iq_pkg.sv
// Package: shared operation-class encoding for the integer issue queue.
// Assumes: the two-bit class values are fixed by the rename stage that fills the queue.
package iq_pkg;
    typedef enum logic [1:0] {
        CLS_GEN  = 2'd0,
        CLS_BRSH = 2'd1,
        CLS_MUL  = 2'd2,
        CLS_DIV  = 2'd3
    } op_cls_e;
endpackage

// File: rtl/iq_alloc.sv
// Module: iq_alloc
// Hands each requesting lane the lowest-numbered free slot not already taken by a lower lane.
// It also reports how many slots are free and how many lanes ask.
// Assumes: occupancy is the registered valid vector; slots issuing this cycle still count as occupied.
module iq_alloc #(
    parameter int DEPTH = 16,
    parameter int LANES = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0]            occupied,
    input  logic [LANES-1:0]            lane_req,
    output logic [LANES-1:0][DEPTH-1:0] lane_slot,
    output logic [CNT_W-1:0]            free_cnt,
    output logic [CNT_W-1:0]            req_cnt
);
    // Chained slot search: each lane skips the slots claimed by lanes before it.
    always_comb begin
        logic [DEPTH-1:0] taken;
        logic             found;
        taken = occupied;
        for (int k = 0; k < LANES; k++) begin
            lane_slot[k] = '0;
            found = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                if (lane_req[k] && !taken[i] && !found) begin
                    lane_slot[k][i] = 1'b1;
                    found = 1'b1;
                end
            end
            taken = taken | lane_slot[k];
        end
    end

    // Free-slot count and lane-request count.
    always_comb begin
        free_cnt = CNT_W'(DEPTH);
        req_cnt  = '0;
        for (int i = 0; i < DEPTH; i++) free_cnt = free_cnt - CNT_W'(occupied[i]);
        for (int k = 0; k < LANES; k++) req_cnt = req_cnt + CNT_W'(lane_req[k]);
    end
endmodule

// File: rtl/iq_age_pick.sv
// Module: iq_age_pick
// Picks the oldest candidate using an age matrix; the result is one-hot or zero.
// Assumes: elder[i][j] is 1 when valid entry j is older than entry i, forming a total order over valid entries.
module iq_age_pick #(
    parameter int DEPTH = 16
) (
    input  logic [DEPTH-1:0]            cand,
    input  logic [DEPTH-1:0][DEPTH-1:0] elder,
    output logic [DEPTH-1:0]            pick
);
    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_row
            // An entry wins when no older entry is also a candidate.
            assign pick[i] = cand[i] & ~(|(cand & elder[i]));
        end
    endgenerate
endmodule

// File: rtl/iq_div_timer.sv
// Module: iq_div_timer
// Holds ALU2 busy for BUSY cycles after a divide issues.
// Assumes: start is seen only when port B actually issues a divide; flush does not stop a running divide.
module iq_div_timer #(
    parameter int BUSY = 6,
    localparam int CW = $clog2(BUSY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [CW-1:0] cnt_q;

    // Load on divide issue, count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (start)       cnt_q <= CW'(BUSY);
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/int_issue_queue.sv
// Module: int_issue_queue
// Out-of-order integer issue queue feeding two ALU ports. It writes up to LANES
// instructions per cycle into any free slots, wakes operands on result broadcasts,
// selects the oldest eligible entry per port under class steering, and holds
// port B during a divide.
// Assumes: the caller keeps an instruction offered until can_accept is high;
// tags are physical register numbers; DEPTH >= LANES.
module int_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LANES    = 4,
    parameter int TAG_W    = 6,
    parameter int NBC      = 2,
    parameter int DIV_BUSY = 6,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic [LANES-1:0]            in_valid,
    input  logic [LANES-1:0][TAG_W-1:0] in_src1,
    input  logic [LANES-1:0]            in_src1_rdy,
    input  logic [LANES-1:0][TAG_W-1:0] in_src2,
    input  logic [LANES-1:0]            in_src2_rdy,
    input  logic [LANES-1:0][TAG_W-1:0] in_dst,
    input  logic [LANES-1:0][1:0]       in_cls,
    output logic                        can_accept,
    input  logic [NBC-1:0]              bc_valid,
    input  logic [NBC-1:0][TAG_W-1:0]   bc_tag,
    output logic                        iss_a_valid,
    output logic [TAG_W-1:0]            iss_a_src1,
    output logic [TAG_W-1:0]            iss_a_src2,
    output logic [TAG_W-1:0]            iss_a_dst,
    output logic [1:0]                  iss_a_cls,
    output logic                        iss_b_valid,
    output logic [TAG_W-1:0]            iss_b_src1,
    output logic [TAG_W-1:0]            iss_b_src2,
    output logic [TAG_W-1:0]            iss_b_dst,
    output logic [1:0]                  iss_b_cls
);
    localparam int NPICK = 3; // 0: port A restricted, 1: port A general, 2: port B

    logic [DEPTH-1:0]            v_q, s1r_q, s2r_q;
    logic [TAG_W-1:0]            s1_q [DEPTH];
    logic [TAG_W-1:0]            s2_q [DEPTH];
    logic [TAG_W-1:0]            dst_q [DEPTH];
    op_cls_e                     cls_q [DEPTH];
    logic [DEPTH-1:0][DEPTH-1:0] elder_q;

    logic [LANES-1:0][DEPTH-1:0] lane_slot;
    logic [CNT_W-1:0]            free_cnt, req_cnt;
    logic                        wr_ok, div_busy, div_start;
    logic [DEPTH-1:0]            alloc_mask, rdy, pick_a, pick_b;
    logic [DEPTH-1:0]            s1_hit, s2_hit;
    logic [LANES-1:0]            in1_hit, in2_hit;
    logic [DEPTH-1:0]            new_row [DEPTH];
    logic [DEPTH-1:0]            cand_v [NPICK];
    logic [DEPTH-1:0]            pick_v [NPICK];

    iq_alloc #(.DEPTH(DEPTH), .LANES(LANES)) u_alloc (
        .occupied (v_q),
        .lane_req (in_valid),
        .lane_slot(lane_slot),
        .free_cnt (free_cnt),
        .req_cnt  (req_cnt)
    );

    assign can_accept = (free_cnt >= req_cnt);
    assign wr_ok      = can_accept & ~flush;

    // Slots that receive a new instruction at the coming edge.
    always_comb begin
        alloc_mask = '0;
        for (int k = 0; k < LANES; k++)
            alloc_mask = alloc_mask | (lane_slot[k] & {DEPTH{wr_ok}});
    end

    // Associative tag compare against the result broadcasts, for stored and incoming operands.
    always_comb begin
        s1_hit = '0; s2_hit = '0; in1_hit = '0; in2_hit = '0;
        for (int b = 0; b < NBC; b++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (bc_valid[b] && bc_tag[b] == s1_q[i]) s1_hit[i] = 1'b1;
                if (bc_valid[b] && bc_tag[b] == s2_q[i]) s2_hit[i] = 1'b1;
            end
            for (int k = 0; k < LANES; k++) begin
                if (bc_valid[b] && bc_tag[b] == in_src1[k]) in1_hit[k] = 1'b1;
                if (bc_valid[b] && bc_tag[b] == in_src2[k]) in2_hit[k] = 1'b1;
            end
        end
    end

    // Candidate vectors for the three pickers, by class and port state.
    always_comb begin
        rdy = v_q & s1r_q & s2r_q & {DEPTH{~flush}};
        for (int i = 0; i < DEPTH; i++) begin
            cand_v[0][i] = rdy[i] & (cls_q[i] == CLS_BRSH);
            cand_v[1][i] = rdy[i] & (cls_q[i] == CLS_GEN);
            cand_v[2][i] = rdy[i] & (cls_q[i] != CLS_BRSH) & ~pick_a[i] & ~div_busy;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NPICK; g++) begin : g_pick
            iq_age_pick #(.DEPTH(DEPTH)) u_pick (
                .cand (cand_v[g]),
                .elder(elder_q),
                .pick (pick_v[g])
            );
        end
    endgenerate

    assign pick_a = (|cand_v[0]) ? pick_v[0] : pick_v[1];
    assign pick_b = pick_v[2];

    // One-hot read-out of the selected entries onto the two issue ports.
    always_comb begin
        iss_a_src1 = '0; iss_a_src2 = '0; iss_a_dst = '0; iss_a_cls = '0;
        iss_b_src1 = '0; iss_b_src2 = '0; iss_b_dst = '0; iss_b_cls = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (pick_a[i]) begin
                iss_a_src1 |= s1_q[i]; iss_a_src2 |= s2_q[i];
                iss_a_dst  |= dst_q[i]; iss_a_cls |= 2'(cls_q[i]);
            end
            if (pick_b[i]) begin
                iss_b_src1 |= s1_q[i]; iss_b_src2 |= s2_q[i];
                iss_b_dst  |= dst_q[i]; iss_b_cls |= 2'(cls_q[i]);
            end
        end
    end

    assign iss_a_valid = |pick_a;
    assign iss_b_valid = |pick_b;
    assign div_start   = iss_b_valid && (iss_b_cls == 2'(CLS_DIV));

    iq_div_timer #(.BUSY(DIV_BUSY)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .start(div_start),
        .busy (div_busy)
    );

    // Age rows for new entries: older are surviving valid slots and lower lanes of this cycle.
    always_comb begin
        logic [DEPTH-1:0] prior;
        prior = '0;
        for (int i = 0; i < DEPTH; i++) new_row[i] = '0;
        for (int k = 0; k < LANES; k++) begin
            for (int i = 0; i < DEPTH; i++)
                if (wr_ok && lane_slot[k][i]) new_row[i] = (v_q & ~alloc_mask) | prior;
            prior = prior | (lane_slot[k] & {DEPTH{wr_ok}});
        end
    end

    // Entry state: flush, release on issue, wakeup, then writes of new instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q     <= '0;
            s1r_q   <= '0;
            s2r_q   <= '0;
            elder_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_mask[i]) elder_q[i] <= new_row[i];
                else               elder_q[i] <= elder_q[i] & ~alloc_mask;
                if (flush) begin
                    v_q[i] <= 1'b0;
                end else begin
                    if (pick_a[i] || pick_b[i]) v_q[i] <= 1'b0;
                    if (s1_hit[i]) s1r_q[i] <= 1'b1;
                    if (s2_hit[i]) s2r_q[i] <= 1'b1;
                    for (int k = 0; k < LANES; k++) begin
                        if (wr_ok && lane_slot[k][i]) begin
                            v_q[i]   <= 1'b1;
                            s1_q[i]  <= in_src1[k];
                            s2_q[i]  <= in_src2[k];
                            dst_q[i] <= in_dst[k];
                            cls_q[i] <= op_cls_e'(in_cls[k]);
                            s1r_q[i] <= in_src1_rdy[k] | in1_hit[k];
                            s2r_q[i] <= in_src2_rdy[k] | in2_hit[k];
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/iq_checker.sv
// Module: iq_checker
// Port-level properties of the integer issue queue, attached by bind.
// Assumes: the class encoding of iq_pkg and the same DIV_BUSY as the queue.
module iq_checker
    import iq_pkg::*;
#(
    parameter int DIV_BUSY = 6,
    localparam int CW = $clog2(DIV_BUSY + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       flush,
    input logic       can_accept,
    input logic       iss_a_valid,
    input logic [1:0] iss_a_cls,
    input logic       iss_b_valid,
    input logic [1:0] iss_b_cls
);
    logic [CW-1:0] win_q;

    // Independent count of the divide hold window seen at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n)                                           win_q <= '0;
        else if (iss_b_valid && iss_b_cls == 2'(CLS_DIV))     win_q <= CW'(DIV_BUSY);
        else if (win_q != '0)                                 win_q <= win_q - 1'b1;
    end

    // R3
    porta_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_a_valid |-> (iss_a_cls == 2'(CLS_GEN) || iss_a_cls == 2'(CLS_BRSH)));

    // R3
    portb_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_b_valid |-> (iss_b_cls != 2'(CLS_BRSH)));

    // R9
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != '0) |-> !iss_b_valid);

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!iss_a_valid && !iss_b_valid));

    // R10
    flush_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> can_accept);
endmodule

bind int_issue_queue iq_checker #(.DIV_BUSY(DIV_BUSY)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .can_accept (can_accept),
    .iss_a_valid(iss_a_valid),
    .iss_a_cls  (iss_a_cls),
    .iss_b_valid(iss_b_valid),
    .iss_b_cls  (iss_b_cls)
);

// File: tb/sim_int_issue_queue.sv
// Bench: vector table of single instructions, then directed tests for
// fill, flush, wakeup, same-cycle wakeup, age order, steering and divide hold.
`timescale 1ns/100ps
module sim_int_issue_queue;
    localparam int LANES = 4, TAG_W = 6, NBC = 2, DIV_BUSY = 6;
    localparam logic [1:0] GEN = 2'd0, BRSH = 2'd1, MUL = 2'd2, DIV = 2'd3;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic [LANES-1:0]            in_valid = '0, in_src1_rdy = '0, in_src2_rdy = '0;
    logic [LANES-1:0][TAG_W-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
    logic [LANES-1:0][1:0]       in_cls = '0;
    logic [NBC-1:0]              bc_valid = '0;
    logic [NBC-1:0][TAG_W-1:0]   bc_tag = '0;
    logic                        can_accept, iss_a_valid, iss_b_valid;
    logic [TAG_W-1:0]            iss_a_src1, iss_a_src2, iss_a_dst;
    logic [TAG_W-1:0]            iss_b_src1, iss_b_src2, iss_b_dst;
    logic [1:0]                  iss_a_cls, iss_b_cls;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    int_issue_queue #(.LANES(LANES), .TAG_W(TAG_W), .NBC(NBC), .DIV_BUSY(DIV_BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_src1(in_src1), .in_src1_rdy(in_src1_rdy),
        .in_src2(in_src2), .in_src2_rdy(in_src2_rdy), .in_dst(in_dst), .in_cls(in_cls),
        .can_accept(can_accept), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .iss_a_valid(iss_a_valid), .iss_a_src1(iss_a_src1), .iss_a_src2(iss_a_src2),
        .iss_a_dst(iss_a_dst), .iss_a_cls(iss_a_cls),
        .iss_b_valid(iss_b_valid), .iss_b_src1(iss_b_src1), .iss_b_src2(iss_b_src2),
        .iss_b_dst(iss_b_dst), .iss_b_cls(iss_b_cls));

    // Vector: {class, destination tag, expected port (0 = A, 1 = B)}
    localparam logic [8:0] VEC [8] = '{
        {GEN, 6'd1, 1'b0}, {BRSH, 6'd2, 1'b0}, {MUL, 6'd3, 1'b1}, {DIV, 6'd4, 1'b1},
        {GEN, 6'd5, 1'b0}, {MUL, 6'd6, 1'b1}, {BRSH, 6'd7, 1'b0}, {DIV, 6'd8, 1'b1}};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge and clear the one-cycle inputs.
    task automatic tick();
        @(posedge clk);
        #0.5;
        in_valid = '0; bc_valid = '0; flush = 1'b0;
    endtask

    task automatic settle();
        #0.5;
    endtask

    task automatic put(input int k, input logic [1:0] c, input int d,
                       input int s1, input logic r1, input int s2, input logic r2);
        in_valid[k] = 1'b1; in_cls[k] = c; in_dst[k] = TAG_W'(d);
        in_src1[k] = TAG_W'(s1); in_src1_rdy[k] = r1;
        in_src2[k] = TAG_W'(s2); in_src2_rdy[k] = r2;
    endtask

    task automatic accept_for(input logic [LANES-1:0] lanes, output logic ok);
        logic [LANES-1:0] keep;
        keep = in_valid;
        in_valid = lanes; #0.2; ok = can_accept; in_valid = keep; #0.1;
    endtask

    initial begin
        logic ok;
        // R11: reset state.
        tick(); tick(); tick();
        settle();
        check("R11 no issue A in reset", int'(iss_a_valid), 0);
        check("R11 no issue B in reset", int'(iss_b_valid), 0);
        accept_for(4'b1111, ok);
        check("R11 four lanes accepted after reset", int'(ok), 1);
        rst_n = 1'b1;
        tick();

        // R3 vector walk: one ready instruction per vector, checked on its port the next cycle.
        for (int v = 0; v < 8; v++) begin
            put(0, VEC[v][8:7], int'(VEC[v][6:1]), 60, 1'b1, 61, 1'b1);
            tick(); settle();
            if (VEC[v][0]) begin
                check("R3 port B valid", int'(iss_b_valid), 1);
                check("R3 port B dst", int'(iss_b_dst), int'(VEC[v][6:1]));
                check("R3 port A idle", int'(iss_a_valid), 0);
            end else begin
                check("R3 port A valid", int'(iss_a_valid), 1);
                check("R3 port A dst", int'(iss_a_dst), int'(VEC[v][6:1]));
                check("R3 port B idle", int'(iss_b_valid), 0);
            end
            tick();
            if (VEC[v][8:7] == DIV) repeat (DIV_BUSY) tick();
        end

        // R1/R2: fill 15 waiting entries plus one ready entry.
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < LANES; k++) put(k, GEN, 16 + 4*c + k, 50, 1'b0, 61, 1'b1);
            if (c == 3) put(3, GEN, 40, 60, 1'b1, 61, 1'b1);
            tick();
        end
        settle();
        put(0, GEN, 41, 60, 1'b1, 61, 1'b1);
        #0.2;
        check("R1 full queue refuses one lane", int'(can_accept), 0);
        check("R2 ready entry issues on A", int'(iss_a_dst), 40);
        tick(); settle();
        accept_for(4'b0001, ok);
        check("R2 released slot accepts one lane", int'(ok), 1);
        accept_for(4'b0011, ok);
        check("R2 only one slot released", int'(ok), 0);
        check("R1 refused write not stored", int'(iss_a_valid), 0);

        // R10: flush, then broadcast the old waiting tag.
        flush = 1'b1;
        settle();
        check("R10 no issue during flush", int'(iss_a_valid | iss_b_valid), 0);
        tick(); settle();
        accept_for(4'b1111, ok);
        check("R10 empty after flush", int'(ok), 1);
        bc_valid[0] = 1'b1; bc_tag[0] = 6'd50;
        tick(); settle();
        check("R10 flushed entries stay dead", int'(iss_a_valid | iss_b_valid), 0);

        // R5: wakeup by broadcast; not issuable in the broadcast cycle.
        put(0, GEN, 30, 33, 1'b0, 61, 1'b1);
        tick();
        bc_valid[1] = 1'b1; bc_tag[1] = 6'd33;
        settle();
        check("R5 waiting entry not issued in broadcast cycle", int'(iss_a_valid), 0);
        tick(); settle();
        check("R5 woken entry issues", int'(iss_a_valid), 1);
        check("R5 woken entry dst", int'(iss_a_dst), 30);
        tick(); settle();
        check("R2 issued entry gone", int'(iss_a_valid), 0);

        // R6: broadcast in the write cycle.
        put(0, GEN, 31, 34, 1'b0, 35, 1'b0);
        bc_valid = 2'b11; bc_tag[0] = 6'd34; bc_tag[1] = 6'd35;
        tick(); settle();
        check("R6 same-cycle wakeup issues", int'(iss_a_valid), 1);
        check("R6 same-cycle wakeup dst", int'(iss_a_dst), 31);
        tick();

        // R8/R4: branch and general together, then two generals.
        put(0, BRSH, 20, 60, 1'b1, 61, 1'b1);
        put(1, GEN, 21, 60, 1'b1, 61, 1'b1);
        tick(); settle();
        check("R8 branch takes A", int'(iss_a_dst), 20);
        check("R8 general goes to B", int'(iss_b_dst), 21);
        check("R4 both ports issue", int'(iss_a_valid & iss_b_valid), 1);
        put(0, GEN, 22, 60, 1'b1, 61, 1'b1);
        put(1, GEN, 23, 60, 1'b1, 61, 1'b1);
        tick(); settle();
        check("R8 oldest general on A", int'(iss_a_dst), 22);
        check("R4 other general on B", int'(iss_b_dst), 23);
        tick();

        // R7: lane order within one cycle.
        put(0, MUL, 13, 60, 1'b1, 61, 1'b1);
        put(1, MUL, 14, 60, 1'b1, 61, 1'b1);
        put(2, MUL, 15, 60, 1'b1, 61, 1'b1);
        tick(); settle();
        check("R7 lane 0 first", int'(iss_b_dst), 13);
        tick(); settle();
        check("R7 lane 1 second", int'(iss_b_dst), 14);
        tick(); settle();
        check("R7 lane 2 third", int'(iss_b_dst), 15);
        tick();

        // R9/R7: divide hold, with multiplies queued across cycles.
        put(0, DIV, 9, 60, 1'b1, 61, 1'b1);
        tick(); settle();
        check("R9 divide issues on B", int'(iss_b_dst), 9);
        for (int n = 1; n <= DIV_BUSY; n++) begin
            tick();
            if (n == 1) put(0, MUL, 11, 60, 1'b1, 61, 1'b1);
            if (n == 2) put(0, MUL, 12, 60, 1'b1, 61, 1'b1);
            settle();
            check("R9 port B held by divide", int'(iss_b_valid), 0);
        end
        tick(); settle();
        check("R9 port B free after hold", int'(iss_b_valid), 1);
        check("R7 older multiply first", int'(iss_b_dst), 11);
        tick(); settle();
        check("R7 younger multiply next", int'(iss_b_dst), 12);
        tick();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule